// File: doc/BRIEF.md
# Interrupt Context Save/Restore Sequencer

This block saves or restores a fixed interrupt context frame through a memory port that carries one word per beat. A save command stores the two trap CSR values (cause and exception PC) and sixteen caller-saved integer registers into the 72 bytes directly below the stack pointer. It then lowers the stack pointer by 72. A restore command reads the same frame back in the reverse order, writes each value to its register or CSR, and raises the stack pointer by 72. It then pulses a trap-return request that carries the restored exception PC.

The block reads the stack pointer (x2) and the saved registers through one combinational register-file read port. It writes restored registers and the new stack pointer through one registered write port. CSR values come in on dedicated inputs and go out through write strobes. Both commands are legal only at machine privilege. The block checks the stack pointer for word alignment before it makes any access. A bus error ends the sequence at once, with an exception code and with the stack pointer left as it was. Only one memory request is outstanding at any time.

Top module: `irq_ctx_seq`

## Requirements
- R1: A command issued at a privilege other than machine (`cmd_priv` != 2'b11) produces an `exc` pulse with `exc_cause` = 2. It issues no memory request and writes no register.
- R2: A command whose stack pointer has either of bits [1:0] set produces an exception and makes no memory access. The cause is 6 for a save and 4 for a restore.
- R3: A save performs exactly 18 word stores, one per slot k = 0..17, at address sp-4-4k. Slot 0 holds the cause CSR and slot 1 holds the exception PC. Slots 2..17 hold x1, x5, x6, x7, x10..x17 and x28..x31, in that order.
- R4: A restore performs exactly 18 word loads at ascending addresses sp+0 .. sp+68, starting with the slot at sp+0 (x31). Each loaded value is written to the register or CSR that the save placed at that address.
- R5: The stack pointer is written once, through the write port at address 2, in the same cycle as `done`. The new value is sp-72 after a save and sp+72 after a restore.
- R6: A restore raises `ret` together with `done`, with `ret_pc` equal to the restored exception PC. A save never raises `ret`.
- R7: A bus error on any beat stops the sequence. The block raises `exc` with cause 7 for a save or cause 5 for a restore. It issues no further request, does not assert `done` and leaves the stack pointer unwritten.
- R8: A request holds `mem_req`, address, data and direction stable until `mem_rsp`. `mem_req` drops in the cycle after the response.
- R9: A command presented while a sequence is running is ignored.
- R10: `done` and `exc` are single-cycle pulses and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe, accepted when idle |
| cmd_pop | input | 1 | 0 = save frame, 1 = restore frame |
| cmd_priv | input | 2 | Privilege of the issuing context, 2'b11 = machine |
| rf_raddr | output | 5 | Register-file read index |
| rf_rdata | input | XLEN | Register-file read data (combinational) |
| rf_we | output | 1 | Register-file write strobe |
| rf_waddr | output | 5 | Register-file write index |
| rf_wdata | output | XLEN | Register-file write data |
| cause_in | input | XLEN | Current trap cause CSR value |
| epc_in | input | XLEN | Current exception PC CSR value |
| csr_we_cause | output | 1 | Write strobe for the cause CSR |
| csr_we_epc | output | 1 | Write strobe for the exception PC CSR |
| csr_wdata | output | XLEN | CSR write data |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | 1 = store, 0 = load |
| mem_addr | output | XLEN | Byte address of the word |
| mem_wdata | output | XLEN | Store data |
| mem_rsp | input | 1 | Response for the outstanding request |
| mem_err | input | 1 | Response carries a bus error |
| mem_rdata | input | XLEN | Load data |
| done | output | 1 | Sequence completed |
| exc | output | 1 | Sequence raised an exception |
| exc_cause | output | 4 | Exception code, valid with `exc` |
| ret | output | 1 | Trap-return request |
| ret_pc | output | XLEN | Return target, valid with `ret` |

## Verification
Several properties are checked on every cycle: request stability and the drop after a response, word alignment of every address, the pulse shape and exclusivity of `done` and `exc`, the limit of stack-pointer writes to the completion cycle, and the immediate illegal-privilege response. Other behaviour shows only in the bench's scenarios, because it depends on the whole frame. That covers the exact slot-to-address mapping of both directions, the data round trip from save to restore, the beat at which a bus error stops the sequence, and the discarding of a command issued mid-sequence.

// File: rtl/ifs_pkg.sv
package ifs_pkg;
  localparam int unsigned FRAME_SLOTS = 18;
  localparam logic [4:0]  SP_REG      = 5'd2;
  localparam logic [1:0]  PRIV_MACHINE = 2'b11;

  localparam logic [3:0] CAUSE_ILLEGAL = 4'd2;
  localparam logic [3:0] CAUSE_LD_MIS  = 4'd4;
  localparam logic [3:0] CAUSE_LD_ACC  = 4'd5;
  localparam logic [3:0] CAUSE_ST_MIS  = 4'd6;
  localparam logic [3:0] CAUSE_ST_ACC  = 4'd7;

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT, S_FIN} ifs_state_t;
  typedef enum logic [1:0] {SRC_GPR, SRC_CAUSE, SRC_EPC} slot_kind_t;
endpackage

// File: rtl/ifs_slot_map.sv
module ifs_slot_map
  import ifs_pkg::*;
#(
  parameter int unsigned IDXW = 5
) (
  input  logic [IDXW-1:0] slot,
  output slot_kind_t      kind,
  output logic [4:0]      gpr
);
  // slot 0/1 are CSRs; the rest walk x1, x5..x7, x10..x17, x28..x31
  always_comb begin
    int s;
    s    = int'(slot);
    kind = SRC_GPR;
    gpr  = 5'd0;
    if (s == 0)       kind = SRC_CAUSE;
    else if (s == 1)  kind = SRC_EPC;
    else if (s == 2)  gpr  = 5'd1;
    else if (s <= 5)  gpr  = 5'(s + 2);
    else if (s <= 13) gpr  = 5'(s + 4);
    else              gpr  = 5'(s + 14);
  end
endmodule

// File: rtl/ifs_slot_ctr.sv
module ifs_slot_ctr #(
  parameter int unsigned SLOTS = 18,
  localparam int unsigned IDXW = $clog2(SLOTS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic            down,
  input  logic            step,
  output logic [IDXW-1:0] idx,
  output logic            last
);
  localparam logic [IDXW-1:0] TOP = IDXW'(SLOTS - 1);
  logic dir_down;

  always_ff @(posedge clk) begin
    if (rst) begin
      idx      <= '0;
      dir_down <= 1'b0;
    end else if (load) begin
      idx      <= down ? TOP : '0;
      dir_down <= down;
    end else if (step) begin
      idx <= dir_down ? idx - 1'b1 : idx + 1'b1;
    end
  end

  assign last = dir_down ? (idx == '0) : (idx == TOP);
endmodule

// File: rtl/ifs_frame_addr.sv
module ifs_frame_addr #(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned SLOTS = 18,
  localparam int unsigned IDXW = $clog2(SLOTS),
  localparam int unsigned WB   = XLEN / 8
) (
  input  logic [XLEN-1:0] frame_base,
  input  logic [IDXW-1:0] idx,
  output logic [XLEN-1:0] addr
);
  // slot k lives at base + (SLOTS-1-k) words: slot 0 sits highest
  logic [XLEN-1:0] word_off;
  assign word_off = XLEN'(SLOTS - 1) - XLEN'(idx);
  assign addr     = frame_base + word_off * XLEN'(WB);
endmodule

// File: rtl/irq_ctx_seq.sv
module irq_ctx_seq
  import ifs_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cmd_valid,
  input  logic            cmd_pop,
  input  logic [1:0]      cmd_priv,
  output logic [4:0]      rf_raddr,
  input  logic [XLEN-1:0] rf_rdata,
  output logic            rf_we,
  output logic [4:0]      rf_waddr,
  output logic [XLEN-1:0] rf_wdata,
  input  logic [XLEN-1:0] cause_in,
  input  logic [XLEN-1:0] epc_in,
  output logic            csr_we_cause,
  output logic            csr_we_epc,
  output logic [XLEN-1:0] csr_wdata,
  output logic            mem_req,
  output logic            mem_we,
  output logic [XLEN-1:0] mem_addr,
  output logic [XLEN-1:0] mem_wdata,
  input  logic            mem_rsp,
  input  logic            mem_err,
  input  logic [XLEN-1:0] mem_rdata,
  output logic            done,
  output logic            exc,
  output logic [3:0]      exc_cause,
  output logic            ret,
  output logic [XLEN-1:0] ret_pc
);
  localparam int unsigned WB          = XLEN / 8;
  localparam int unsigned ALIGN       = $clog2(WB);
  localparam int unsigned IDXW        = $clog2(FRAME_SLOTS);
  localparam logic [XLEN-1:0] FRAME_BYTES = XLEN'(FRAME_SLOTS * WB);

  ifs_state_t      state;
  logic            pop_q;
  logic [XLEN-1:0] frame_base;
  logic [XLEN-1:0] ret_pc_q;
  logic [IDXW-1:0] idx;
  logic            idx_last;
  slot_kind_t      kind;
  logic [4:0]      slot_gpr;
  logic [XLEN-1:0] slot_addr;
  logic            cmd_legal, sp_aligned, start, step;

  assign cmd_legal  = (cmd_priv == PRIV_MACHINE);
  assign sp_aligned = (rf_rdata[ALIGN-1:0] == '0);
  assign start      = (state == S_IDLE) && cmd_valid && cmd_legal && sp_aligned;
  assign step       = (state == S_WAIT) && mem_rsp && !mem_err;

  ifs_slot_ctr #(.SLOTS(FRAME_SLOTS)) u_ctr (
    .clk(clk), .rst(rst), .load(start), .down(cmd_pop), .step(step),
    .idx(idx), .last(idx_last)
  );

  ifs_slot_map #(.IDXW(IDXW)) u_map (
    .slot(idx), .kind(kind), .gpr(slot_gpr)
  );

  ifs_frame_addr #(.XLEN(XLEN), .SLOTS(FRAME_SLOTS)) u_addr (
    .frame_base(frame_base), .idx(idx), .addr(slot_addr)
  );

  // idle reads the stack pointer, otherwise the register of the current slot
  assign rf_raddr = (state == S_IDLE) ? SP_REG : slot_gpr;
  assign ret_pc   = ret_pc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= S_IDLE;
      pop_q        <= 1'b0;
      frame_base   <= '0;
      ret_pc_q     <= '0;
      rf_we        <= 1'b0;
      rf_waddr     <= '0;
      rf_wdata     <= '0;
      csr_we_cause <= 1'b0;
      csr_we_epc   <= 1'b0;
      csr_wdata    <= '0;
      mem_req      <= 1'b0;
      mem_we       <= 1'b0;
      mem_addr     <= '0;
      mem_wdata    <= '0;
      done         <= 1'b0;
      exc          <= 1'b0;
      exc_cause    <= '0;
      ret          <= 1'b0;
    end else begin
      done         <= 1'b0;
      exc          <= 1'b0;
      ret          <= 1'b0;
      rf_we        <= 1'b0;
      csr_we_cause <= 1'b0;
      csr_we_epc   <= 1'b0;
      unique case (state)
        S_IDLE: begin
          if (cmd_valid) begin
            if (!cmd_legal) begin
              exc       <= 1'b1;
              exc_cause <= CAUSE_ILLEGAL;
            end else if (!sp_aligned) begin
              exc       <= 1'b1;
              exc_cause <= cmd_pop ? CAUSE_LD_MIS : CAUSE_ST_MIS;
            end else begin
              pop_q      <= cmd_pop;
              frame_base <= cmd_pop ? rf_rdata : rf_rdata - FRAME_BYTES;
              state      <= S_ISSUE;
            end
          end
        end
        S_ISSUE: begin
          mem_req  <= 1'b1;
          mem_we   <= !pop_q;
          mem_addr <= slot_addr;
          unique case (kind)
            SRC_CAUSE: mem_wdata <= cause_in;
            SRC_EPC:   mem_wdata <= epc_in;
            default:   mem_wdata <= rf_rdata;
          endcase
          state <= S_WAIT;
        end
        S_WAIT: begin
          if (mem_rsp) begin
            mem_req <= 1'b0;
            if (mem_err) begin
              exc       <= 1'b1;
              exc_cause <= pop_q ? CAUSE_LD_ACC : CAUSE_ST_ACC;
              state     <= S_IDLE;
            end else begin
              if (pop_q) begin
                unique case (kind)
                  SRC_CAUSE: begin
                    csr_we_cause <= 1'b1;
                    csr_wdata    <= mem_rdata;
                  end
                  SRC_EPC: begin
                    csr_we_epc <= 1'b1;
                    csr_wdata  <= mem_rdata;
                    ret_pc_q   <= mem_rdata;
                  end
                  default: begin
                    rf_we    <= 1'b1;
                    rf_waddr <= slot_gpr;
                    rf_wdata <= mem_rdata;
                  end
                endcase
              end
              state <= idx_last ? S_FIN : S_ISSUE;
            end
          end
        end
        S_FIN: begin
          done     <= 1'b1;
          ret      <= pop_q;
          rf_we    <= 1'b1;
          rf_waddr <= SP_REG;
          rf_wdata <= pop_q ? frame_base + FRAME_BYTES : frame_base;
          state    <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_illegal_priv_R1: assert property (@(posedge clk) disable iff (rst)
    (state == S_IDLE && cmd_valid && cmd_priv != PRIV_MACHINE)
      |=> (exc && exc_cause == CAUSE_ILLEGAL && !mem_req));

  assert_word_aligned_R2: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (mem_addr[ALIGN-1:0] == '0));

  assert_sp_write_at_done_R5: assert property (@(posedge clk) disable iff (rst)
    (rf_we && rf_waddr == SP_REG) |-> done);

  assert_ret_with_done_R6: assert property (@(posedge clk) disable iff (rst)
    ret |-> done);

  assert_fault_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    exc |-> (!mem_req && !done));

  assert_req_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_rsp) |=> (mem_req && $stable(mem_addr) && $stable(mem_wdata) && $stable(mem_we)));

  assert_req_drop_R8: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_rsp) |=> !mem_req);

  assert_done_exc_excl_R10: assert property (@(posedge clk) disable iff (rst)
    !(done && exc));

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_exc_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    exc |=> !exc);
endmodule

// File: tb/irq_ctx_seq_tb.sv
module irq_ctx_seq_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0, cmd_pop = 1'b0;
  logic [1:0]  cmd_priv = 2'b11;
  logic [4:0]  rf_raddr, rf_waddr;
  logic [31:0] rf_rdata, rf_wdata, csr_wdata, mem_addr, mem_wdata, ret_pc;
  logic        rf_we, csr_we_cause, csr_we_epc, mem_req, mem_we, done, exc, ret;
  logic [3:0]  exc_cause;
  logic        mem_rsp = 1'b0, mem_err = 1'b0;
  logic [31:0] mem_rdata = '0;

  logic [31:0] gpr [32];
  logic [31:0] csr_cause = '0, csr_epc = '0;
  logic [31:0] snap [32];
  logic [31:0] mem_arr [128];

  int checks = 0, failures = 0;
  int done_cnt, exc_cnt, ret_cnt, both_cnt, sp_wr_cnt, hold_err;
  logic [3:0]  last_cause;
  logic [31:0] last_ret_pc;
  int lat = 0, wait_cnt = 0, err_beat = 99, log_n = 0;
  logic [31:0] log_addr [32];
  logic [31:0] log_wd [32];
  logic        log_we [32];
  logic [31:0] seen_addr;
  bit finished = 0;
  int order [16] = '{1, 5, 6, 7, 10, 11, 12, 13, 14, 15, 16, 17, 28, 29, 30, 31};

  always #2 clk = ~clk;

  assign rf_rdata = gpr[rf_raddr];

  irq_ctx_seq #(.XLEN(32)) u_dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_pop(cmd_pop), .cmd_priv(cmd_priv),
    .rf_raddr(rf_raddr), .rf_rdata(rf_rdata), .rf_we(rf_we), .rf_waddr(rf_waddr),
    .rf_wdata(rf_wdata), .cause_in(csr_cause), .epc_in(csr_epc),
    .csr_we_cause(csr_we_cause), .csr_we_epc(csr_we_epc), .csr_wdata(csr_wdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rsp(mem_rsp), .mem_err(mem_err), .mem_rdata(mem_rdata),
    .done(done), .exc(exc), .exc_cause(exc_cause), .ret(ret), .ret_pc(ret_pc)
  );

  // register file, CSR, memory and pulse monitors, all at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      if (rf_we) begin
        gpr[rf_waddr] = rf_wdata;
        if (rf_waddr == 5'd2) sp_wr_cnt++;
      end
      if (csr_we_cause) csr_cause = csr_wdata;
      if (csr_we_epc)   csr_epc   = csr_wdata;
      if (done) done_cnt++;
      if (exc) begin exc_cnt++; last_cause = exc_cause; end
      if (ret) begin ret_cnt++; last_ret_pc = ret_pc; end
      if (done && exc) both_cnt++;
      if (mem_rsp) begin
        mem_rsp = 1'b0;
        mem_err = 1'b0;
      end else if (mem_req) begin
        if (wait_cnt == 0) seen_addr = mem_addr;
        else if (mem_addr != seen_addr) hold_err++;
        if (wait_cnt < lat) wait_cnt++;
        else begin
          wait_cnt = 0;
          if (log_n < 32) begin
            log_addr[log_n] = mem_addr;
            log_we[log_n]   = mem_we;
            log_wd[log_n]   = mem_wdata;
          end
          if (log_n == err_beat) mem_err = 1'b1;
          else if (mem_we) mem_arr[mem_addr[8:2]] = mem_wdata;
          else mem_rdata = mem_arr[mem_addr[8:2]];
          log_n++;
          mem_rsp = 1'b1;
        end
      end
    end
  end

  task automatic check_eq(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] slot_value(int k);
    if (k == 0) return snap[0];
    if (k == 1) return snap[2];
    return snap[order[k-2]];
  endfunction

  task automatic clear_counts();
    #1;
    done_cnt = 0; exc_cnt = 0; ret_cnt = 0; both_cnt = 0;
    sp_wr_cnt = 0; hold_err = 0; log_n = 0; wait_cnt = 0;
  endtask

  task automatic issue(logic pop, logic [1:0] priv);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_pop = pop; cmd_priv = priv;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_end();
    for (int n = 0; n < 2000 && (done_cnt + exc_cnt) == 0; n++) @(negedge clk);
    repeat (6) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check_eq("R10 reset done", 32'(done), 0);
    check_eq("R10 reset exc", 32'(exc), 0);
    check_eq("R8 reset mem_req", 32'(mem_req), 0);
    check_eq("R5 reset rf_we", 32'(rf_we), 0);
  endtask

  task automatic t_push();
    for (int i = 0; i < 32; i++) gpr[i] = 32'hA000_0000 + 32'(i) * 32'h11;
    gpr[2] = 32'h100;
    csr_cause = 32'h8000_000B;
    csr_epc   = 32'h0000_2468;
    snap = gpr;
    snap[0] = csr_cause;
    snap[2] = csr_epc;
    lat = 0; err_beat = 99;
    clear_counts();
    issue(1'b0, 2'b11);
    wait_end();
    check_eq("R3 store count", 32'(log_n), 18);
    for (int k = 0; k < 18; k++) begin
      check_eq("R3 store addr", log_addr[k], 32'h100 - 32'd4 - 32'(4 * k));
      check_eq("R3 store dir", 32'(log_we[k]), 1);
      check_eq("R3 store data", log_wd[k], slot_value(k));
    end
    check_eq("R5 push sp", gpr[2], 32'hB8);
    check_eq("R5 sp writes", 32'(sp_wr_cnt), 1);
    check_eq("R10 done once", 32'(done_cnt), 1);
    check_eq("R6 no ret on push", 32'(ret_cnt), 0);
    check_eq("R10 no both", 32'(both_cnt), 0);
  endtask

  task automatic t_pop();
    for (int i = 0; i < 32; i++) gpr[i] = 32'h0;
    gpr[2] = 32'hB8;
    csr_cause = '0; csr_epc = '0;
    lat = 2; err_beat = 99;
    clear_counts();
    issue(1'b1, 2'b11);
    wait_end();
    check_eq("R4 load count", 32'(log_n), 18);
    for (int j = 0; j < 18; j++) begin
      check_eq("R4 load addr", log_addr[j], 32'hB8 + 32'(4 * j));
      check_eq("R4 load dir", 32'(log_we[j]), 0);
    end
    for (int k = 0; k < 16; k++) check_eq("R4 gpr restored", gpr[order[k]], snap[order[k]]);
    check_eq("R4 cause restored", csr_cause, snap[0]);
    check_eq("R4 epc restored", csr_epc, snap[2]);
    check_eq("R5 pop sp", gpr[2], 32'h100);
    check_eq("R6 ret once", 32'(ret_cnt), 1);
    check_eq("R6 ret pc", last_ret_pc, 32'h2468);
    check_eq("R10 done once pop", 32'(done_cnt), 1);
    check_eq("R8 hold under latency", 32'(hold_err), 0);
  endtask

  task automatic t_illegal();
    gpr[2] = 32'h100;
    clear_counts();
    issue(1'b0, 2'b01);
    wait_end();
    check_eq("R1 exc", 32'(exc_cnt), 1);
    check_eq("R1 cause", 32'(last_cause), 2);
    check_eq("R1 no access", 32'(log_n), 0);
    check_eq("R1 sp kept", gpr[2], 32'h100);
    check_eq("R1 no done", 32'(done_cnt), 0);
    clear_counts();
    issue(1'b1, 2'b00);
    wait_end();
    check_eq("R1 pop cause", 32'(last_cause), 2);
    check_eq("R1 pop no access", 32'(log_n), 0);
  endtask

  task automatic t_misaligned();
    gpr[2] = 32'h102;
    clear_counts();
    issue(1'b0, 2'b11);
    wait_end();
    check_eq("R2 push cause", 32'(last_cause), 6);
    check_eq("R2 push no access", 32'(log_n), 0);
    check_eq("R2 push sp kept", gpr[2], 32'h102);
    clear_counts();
    issue(1'b1, 2'b11);
    wait_end();
    check_eq("R2 pop cause", 32'(last_cause), 4);
    check_eq("R2 pop no access", 32'(log_n), 0);
  endtask

  task automatic t_fault();
    gpr[2] = 32'h100;
    lat = 1; err_beat = 5;
    clear_counts();
    issue(1'b0, 2'b11);
    wait_end();
    check_eq("R7 push cause", 32'(last_cause), 7);
    check_eq("R7 push stopped", 32'(log_n), 6);
    check_eq("R7 push sp unwritten", 32'(sp_wr_cnt), 0);
    check_eq("R7 push no done", 32'(done_cnt), 0);
    gpr[2] = 32'hB8;
    err_beat = 3;
    clear_counts();
    issue(1'b1, 2'b11);
    wait_end();
    check_eq("R7 pop cause", 32'(last_cause), 5);
    check_eq("R7 pop stopped", 32'(log_n), 4);
    check_eq("R7 pop sp kept", gpr[2], 32'hB8);
    check_eq("R7 pop no ret", 32'(ret_cnt), 0);
    err_beat = 99;
  endtask

  task automatic t_busy();
    gpr[2] = 32'h100;
    lat = 3; err_beat = 99;
    clear_counts();
    issue(1'b0, 2'b11);
    repeat (10) @(negedge clk);
    cmd_valid = 1'b1; cmd_pop = 1'b1; cmd_priv = 2'b11;
    @(negedge clk);
    cmd_valid = 1'b0;
    wait_end();
    check_eq("R9 stores only", 32'(log_n), 18);
    check_eq("R9 last beat store", 32'(log_we[17]), 1);
    check_eq("R9 single done", 32'(done_cnt), 1);
    check_eq("R9 single sp write", 32'(sp_wr_cnt), 1);
    check_eq("R9 sp from push", gpr[2], 32'hB8);
    check_eq("R8 hold stable", 32'(hold_err), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) gpr[i] = '0;
    for (int i = 0; i < 128; i++) mem_arr[i] = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_push();
    t_pop();
    t_illegal();
    t_misaligned();
    t_fault();
    t_busy();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule